// File: doc/BRIEF.md
# Adaptive Interrupt Coalescing Controller

This block sits beside a receive path and decides when the host is told about newly arrived packets. It sees a one-cycle strobe for every arriving packet and a one-cycle strobe for every packet the host has finished with. From these it keeps a running backlog of unprocessed packets.

While the backlog is moderate the block is in interrupt mode. It raises a one-cycle interrupt pulse once a configured number of packets has gathered since the previous pulse. It also raises one when the oldest packet of the current batch has waited a configured number of cycles, whichever happens first. A batch size of one gives an interrupt for every packet.

When the backlog climbs above a high watermark, the block masks its interrupt and raises a polling-mode flag, so the host drains the ring without further interrupts. It returns to interrupt mode only once the backlog has dropped below a separate, lower watermark. This gap of hysteresis stops the block from flipping between modes on every packet.

The watermark machine has two states. IRQ_MODE is the reset state and the only one in which pulses may leave the block. POLL_MODE masks all pulses and raises the polling flag. The transition "overload" goes from IRQ_MODE to POLL_MODE when the backlog exceeds the high watermark. The transition "drained" goes from POLL_MODE to IRQ_MODE when the backlog falls below the low watermark.

The batch machine also has two states. GATHER_IDLE means no packet is waiting for an interrupt. GATHER_OPEN means at least one packet is waiting and the latency timer runs. It has three transitions:
- "first" goes from GATHER_IDLE to GATHER_OPEN when a packet arrives and the batch is not complete at once.
- "fire" goes from either state to GATHER_IDLE when the count threshold or the timeout is reached.
- "mask" goes from either state to GATHER_IDLE when pulses are not allowed, and discards the gathered count.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, `irq_pulse` is 0, `poll_mode` is 0 (interrupt mode) and `backlog` is 0.
- R2: In interrupt mode with `cfg_batch` = N ≥ 2, a one-cycle `irq_pulse` appears in the cycle right after the clock edge that samples the N-th arrival since the previous pulse (or since the batch was opened). Unless that happened, the arrivals up to that point produce no pulse.
- R3: A `cfg_batch` of 1 (or 0) selects per-packet mode: every sampled arrival in interrupt mode gives a pulse in the next cycle, so back-to-back arrivals give back-to-back pulses.
- R4: If a batch is still incomplete, a pulse appears exactly `cfg_timeout` cycles after the edge that sampled the batch's first packet. `cfg_timeout` values 0 and 1 behave alike.
- R5: When the count threshold and the timeout are reached at the same edge, exactly one single-cycle pulse results, and both the count and the timer restart. Any pulse also clears the gathered count, including a packet arriving at that edge.
- R6: `backlog` rises by one per arrival and falls by one per consume. An arrival and a consume at the same edge leave it unchanged. It saturates at 2^BACKLOG_W−1 and a consume at 0 keeps it at 0.
- R7: In interrupt mode, a `backlog` above `cfg_hi_wm` sets `poll_mode` at the next edge. No pulse is produced at that edge or while `poll_mode` is 1, and the gathered batch is discarded.
- R8: In polling mode, a `backlog` below `cfg_lo_wm` clears `poll_mode` at the next edge. Batch counting then starts again from zero.
- R9: `cfg_err` is 1 exactly when `cfg_lo_wm` ≥ `cfg_hi_wm`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_arrive | input | 1 | One strobe per received packet |
| pkt_consume | input | 1 | One strobe per packet the host finished |
| cfg_batch | input | CNT_W | Packets per interrupt (0 or 1: per packet) |
| cfg_timeout | input | TMR_W | Latency limit in cycles for the oldest batched packet |
| cfg_hi_wm | input | BACKLOG_W | Backlog level above which polling mode starts |
| cfg_lo_wm | input | BACKLOG_W | Backlog level below which polling mode ends |
| irq_pulse | output | 1 | Registered one-cycle interrupt pulse |
| poll_mode | output | 1 | Registered polling-mode flag (interrupt masked) |
| backlog | output | BACKLOG_W | Registered count of unprocessed packets |
| cfg_err | output | 1 | Watermark setting invalid |

## Verification
Two pairs of functions can coincide at one edge. The first pair is the count threshold and the latency timeout. A directed case sets the batch size equal to the timeout plus one and sends one arrival per cycle, so both triggers land on the same edge. The check there is that exactly one pulse appears in the window that follows. The second pair is a pending pulse and entry into polling mode. It is provoked by sweeping dense arrival patterns with low watermarks. The bench's arithmetic model then requires no pulse in the cycle `poll_mode` rises, and a fresh count after it falls.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    typedef enum logic {
        IRQ_MODE  = 1'b0,
        POLL_MODE = 1'b1
    } wm_state_e;

    typedef enum logic {
        GATHER_IDLE = 1'b0,
        GATHER_OPEN = 1'b1
    } gather_state_e;

endpackage

// File: rtl/backlog_tracker.sv
module backlog_tracker #(
    parameter int BACKLOG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arrive,
    input  logic                 consume,
    output logic [BACKLOG_W-1:0] level
);
    localparam logic [BACKLOG_W-1:0] LVL_MAX = {BACKLOG_W{1'b1}};
    localparam logic [BACKLOG_W-1:0] LVL_ONE = BACKLOG_W'(1);

    logic [BACKLOG_W-1:0] level_d;

    always_comb begin
        level_d = level;
        if (arrive && !consume && level != LVL_MAX) begin
            level_d = level + LVL_ONE;
        end else if (consume && !arrive && level != '0) begin
            level_d = level - LVL_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level <= '0;
        else        level <= level_d;
    end

    // R6: simultaneous strobes leave the level untouched
    a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && consume) |=> $stable(level));
    // R6: saturation at the top
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && !consume && level == LVL_MAX) |=> (level == LVL_MAX));
    // R6: no wrap below zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !arrive && level == '0) |=> (level == '0));
endmodule

// File: rtl/wm_mode_fsm.sv
module wm_mode_fsm
    import irq_coal_pkg::*;
#(
    parameter int BACKLOG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BACKLOG_W-1:0] level,
    input  logic [BACKLOG_W-1:0] hi_wm,
    input  logic [BACKLOG_W-1:0] lo_wm,
    output logic                 poll_mode,
    output logic                 fire_allow
);
    wm_state_e state_q, state_d;
    logic      over_hi, under_lo;

    assign over_hi  = level > hi_wm;
    assign under_lo = level < lo_wm;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_MODE:  if (over_hi)  state_d = POLL_MODE;   // overload
            POLL_MODE: if (under_lo) state_d = IRQ_MODE;    // drained
            default:   state_d = IRQ_MODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_MODE;
        else        state_q <= state_d;
    end

    // outputs
    assign poll_mode  = (state_q == POLL_MODE);
    assign fire_allow = (state_q == IRQ_MODE) && !over_hi;

    // R7: overload is taken one edge after the level rises above the high mark
    a_r7_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_mode && over_hi) |=> poll_mode);
    // R8: drained is taken one edge after the level drops below the low mark
    a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_mode && under_lo) |=> !poll_mode);
    // R8: polling persists while the level is not below the low mark
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_mode && !under_lo) |=> poll_mode);
endmodule

// File: rtl/batch_engine.sv
module batch_engine
    import irq_coal_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arrive,
    input  logic             fire_allow,
    input  logic [CNT_W-1:0] cfg_batch,
    input  logic [TMR_W-1:0] cfg_timeout,
    output logic             irq_pulse
);
    localparam logic [CNT_W:0]   CNT_ONE = (CNT_W+1)'(1);
    localparam logic [TMR_W:0]   TMR_ONE = (TMR_W+1)'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

    gather_state_e    st_q, st_d;
    logic [CNT_W-1:0] pend_q, pend_d;
    logic [TMR_W-1:0] age_q, age_d;
    logic             cnt_hit, tmo_hit, fire;

    assign cnt_hit = arrive && (({1'b0, pend_q} + CNT_ONE) >= {1'b0, cfg_batch});
    assign tmo_hit = (st_q == GATHER_OPEN) &&
                     (({1'b0, age_q} + TMR_ONE) >= {1'b0, cfg_timeout});
    assign fire    = fire_allow && (cnt_hit || tmo_hit);

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        age_d  = age_q;
        if (!fire_allow || fire) begin
            st_d   = GATHER_IDLE;              // mask / fire
            pend_d = '0;
            age_d  = '0;
        end else begin
            unique case (st_q)
                GATHER_IDLE: begin
                    if (arrive) begin          // first
                        st_d   = GATHER_OPEN;
                        pend_d = CNT_W'(1);
                        age_d  = '0;
                    end
                end
                GATHER_OPEN: begin
                    if (arrive && pend_q != CNT_MAX) pend_d = pend_q + CNT_W'(1);
                    if (age_q != TMR_MAX)            age_d  = age_q + TMR_W'(1);
                end
                default: st_d = GATHER_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= GATHER_IDLE;
            pend_q <= '0;
            age_q  <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            age_q  <= age_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= fire;
    end

    // R5: a pulse always leaves the batch empty, so a coincidence cannot repeat
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (st_q == GATHER_IDLE && pend_q == '0));
    // R4: an open batch never outlives its latency limit
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GATHER_OPEN && cfg_timeout != '0) |-> (age_q < cfg_timeout));
    // R7: a masked cycle leaves nothing gathered
    a_r7_discard: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_allow |=> (st_q == GATHER_IDLE && !irq_pulse));
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl #(
    parameter int BACKLOG_W = 8,
    parameter int CNT_W     = 8,
    parameter int TMR_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_arrive,
    input  logic                 pkt_consume,
    input  logic [CNT_W-1:0]     cfg_batch,
    input  logic [TMR_W-1:0]     cfg_timeout,
    input  logic [BACKLOG_W-1:0] cfg_hi_wm,
    input  logic [BACKLOG_W-1:0] cfg_lo_wm,
    output logic                 irq_pulse,
    output logic                 poll_mode,
    output logic [BACKLOG_W-1:0] backlog,
    output logic                 cfg_err
);
    logic fire_allow;

    backlog_tracker #(.BACKLOG_W(BACKLOG_W)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .arrive  (pkt_arrive),
        .consume (pkt_consume),
        .level   (backlog)
    );

    wm_mode_fsm #(.BACKLOG_W(BACKLOG_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (backlog),
        .hi_wm      (cfg_hi_wm),
        .lo_wm      (cfg_lo_wm),
        .poll_mode  (poll_mode),
        .fire_allow (fire_allow)
    );

    batch_engine #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_batch (
        .clk         (clk),
        .rst_n       (rst_n),
        .arrive      (pkt_arrive),
        .fire_allow  (fire_allow),
        .cfg_batch   (cfg_batch),
        .cfg_timeout (cfg_timeout),
        .irq_pulse   (irq_pulse)
    );

    assign cfg_err = (cfg_lo_wm >= cfg_hi_wm);

    // R7: the interrupt stays quiet whenever polling mode is shown
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        poll_mode |-> !irq_pulse);
    // R3: per-packet mode answers every accepted arrival
    a_r3_each: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_batch <= CNT_W'(1) && pkt_arrive && !poll_mode && backlog <= cfg_hi_wm)
        |=> irq_pulse);
endmodule

// File: tb/irq_coalesce_ctrl_bench.sv
module irq_coalesce_ctrl_bench;
    localparam int BW = 4;
    localparam int CW = 4;
    localparam int TW = 6;
    localparam int BL_MAX = (1 << BW) - 1;
    localparam int TM_MAX = (1 << TW) - 1;
    localparam int CN_MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_arrive = 1'b0;
    logic          pkt_consume = 1'b0;
    logic [CW-1:0] cfg_batch = CW'(1);
    logic [TW-1:0] cfg_timeout = TW'(1);
    logic [BW-1:0] cfg_hi_wm = BW'(10);
    logic [BW-1:0] cfg_lo_wm = BW'(4);
    logic          irq_pulse, poll_mode, cfg_err;
    logic [BW-1:0] backlog;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // arithmetic model state
    int m_bl, m_pend, m_age;
    bit m_poll, m_irq;
    int pulses;

    always #5 clk = ~clk;

    irq_coalesce_ctrl #(.BACKLOG_W(BW), .CNT_W(CW), .TMR_W(TW)) u_irq_coalesce_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_arrive(pkt_arrive), .pkt_consume(pkt_consume),
        .cfg_batch(cfg_batch), .cfg_timeout(cfg_timeout),
        .cfg_hi_wm(cfg_hi_wm), .cfg_lo_wm(cfg_lo_wm),
        .irq_pulse(irq_pulse), .poll_mode(poll_mode), .backlog(backlog), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pkt_arrive = 1'b0; pkt_consume = 1'b0;
        repeat (2) @(negedge clk);
        m_bl = 0; m_pend = 0; m_age = 0; m_poll = 0; m_irq = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic step(input bit a, input bit c, input string tag);
        bit allow, hit_c, hit_t, fire;
        int nb, nbl;
        pkt_arrive = a; pkt_consume = c;
        nb    = int'(cfg_batch);
        allow = !m_poll && !(m_bl > int'(cfg_hi_wm));
        hit_c = a && (m_pend + 1 >= nb);
        hit_t = (m_pend > 0) && (m_age + 1 >= int'(cfg_timeout));
        fire  = allow && (hit_c || hit_t);
        if (!allow || fire) begin
            m_pend = 0; m_age = 0;
        end else if (m_pend == 0) begin
            if (a) begin m_pend = 1; m_age = 0; end
        end else begin
            if (a && m_pend < CN_MAX) m_pend++;
            if (m_age < TM_MAX) m_age++;
        end
        if (!m_poll && m_bl > int'(cfg_hi_wm))      m_poll = 1;
        else if (m_poll && m_bl < int'(cfg_lo_wm))  m_poll = 0;
        nbl = m_bl;
        if (a && !c && m_bl < BL_MAX) nbl = m_bl + 1;
        if (c && !a && m_bl > 0)      nbl = m_bl - 1;
        m_bl  = nbl;
        m_irq = fire;
        @(negedge clk);
        if (irq_pulse) pulses++;
        check(irq_pulse == m_irq, tag, "irq_pulse", int'(irq_pulse), int'(m_irq));
        check(poll_mode == m_poll, "R7/R8", "poll_mode", int'(poll_mode), int'(m_poll));
        check(int'(backlog) == m_bl, "R6", "backlog", int'(backlog), m_bl);
    endtask

    task automatic set_cfg(input int nb, input int t, input int hi, input int lo);
        cfg_batch = CW'(nb); cfg_timeout = TW'(t);
        cfg_hi_wm = BW'(hi); cfg_lo_wm = BW'(lo);
    endtask

    initial begin
        logic [15:0] lfsr;
        int          thr;
        pulses = 0;
        do_reset();
        // R1: reset state
        check(irq_pulse == 1'b0, "R1", "irq_pulse", int'(irq_pulse), 0);
        check(poll_mode == 1'b0, "R1", "poll_mode", int'(poll_mode), 0);
        check(backlog == '0, "R1", "backlog", int'(backlog), 0);

        // R9: watermark check
        set_cfg(1, 1, 6, 6); #1;
        check(cfg_err == 1'b1, "R9", "cfg_err equal", int'(cfg_err), 1);
        set_cfg(1, 1, 6, 7); #1;
        check(cfg_err == 1'b1, "R9", "cfg_err above", int'(cfg_err), 1);
        set_cfg(1, 1, 6, 5); #1;
        check(cfg_err == 1'b0, "R9", "cfg_err ok", int'(cfg_err), 0);

        // R3: per-packet mode, back-to-back arrivals
        set_cfg(1, 40, 14, 2); do_reset();
        pulses = 0;
        for (int i = 0; i < 4; i++) step(1, 1, "R3");
        step(0, 0, "R3");
        check(pulses == 4, "R3", "pulse count", pulses, 4);

        // R2: batches of three
        set_cfg(3, 40, 14, 2); do_reset();
        pulses = 0;
        for (int i = 0; i < 9; i++) step(1, 1, "R2");
        step(0, 0, "R2");
        check(pulses == 3, "R2", "pulse count", pulses, 3);

        // R4: lone packet, timeout 3 and then timeout 0
        set_cfg(4, 3, 14, 2); do_reset();
        pulses = 0;
        step(1, 0, "R4");
        for (int i = 0; i < 5; i++) step(0, 0, "R4");
        check(pulses == 1, "R4", "pulse count", pulses, 1);
        cfg_timeout = TW'(0);
        step(1, 0, "R4"); step(0, 0, "R4"); step(0, 0, "R4");

        // R5: count and timeout reached at one edge
        set_cfg(3, 2, 14, 2); do_reset();
        pulses = 0;
        step(1, 1, "R5"); step(1, 1, "R5"); step(1, 1, "R5");
        for (int i = 0; i < 4; i++) step(0, 0, "R5");
        check(pulses == 1, "R5", "pulse count", pulses, 1);

        // R6: saturation and underflow
        set_cfg(CN_MAX, TM_MAX, BL_MAX, 1); do_reset();
        for (int i = 0; i < BL_MAX + 4; i++) step(1, 0, "R6");
        check(int'(backlog) == BL_MAX, "R6", "saturated", int'(backlog), BL_MAX);
        step(1, 1, "R6");
        do_reset();
        step(0, 1, "R6");
        check(backlog == '0, "R6", "floor", int'(backlog), 0);

        // R7/R8: hysteresis and masking
        set_cfg(2, 5, 6, 2); do_reset();
        pulses = 0;
        for (int i = 0; i < 9; i++) step(1, 0, "R7");
        check(poll_mode == 1'b1, "R7", "entered polling", int'(poll_mode), 1);
        for (int i = 0; i < 3; i++) step(1, 0, "R7");
        for (int i = 0; i < 14; i++) step(0, 1, "R8");
        check(poll_mode == 1'b0, "R8", "left polling", int'(poll_mode), 0);
        step(1, 0, "R8"); step(1, 0, "R8"); step(0, 0, "R8");

        // sweep over batch size, timeout, watermarks and load
        lfsr = 16'hACE1;
        for (int nb = 0; nb <= 4; nb++) begin
            for (int ti = 0; ti < 4; ti++) begin
                for (int wm = 0; wm < 2; wm++) begin
                    set_cfg(nb, (ti == 0) ? 0 : 2 * ti - 1,
                            (wm == 0) ? 10 : 6, (wm == 0) ? 4 : 2);
                    do_reset();
                    for (int cyc = 0; cyc < 240; cyc++) begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        thr = (cyc < 120) ? 5 : 2;
                        step(int'(lfsr[3:0]) < 4 * thr / 2 ? 1'b1 : 1'b0,
                             int'(lfsr[7:4]) < ((cyc < 120) ? 4 : 12) ? 1'b1 : 1'b0,
                             "R2/R3/R4/R5/R7");
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not finish act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule